// File: doc/BRIEF.md
# Pipelined Nonrestoring Fractional Divider

This block divides a double-width fractional dividend by a normalized single-width fractional divisor, yielding one quotient bit per row of a linear array of add/subtract stages. Each row shifts the running partial remainder left, brings in the next unconsumed dividend bit, and then either subtracts or adds the divisor. The row's sign result is both its quotient bit and the operation choice for the following row. Because no row ever undoes its own step, no restoring multiplexer is needed.

Every row is followed by a register, so the clock period is one row's carry ripple. A new division may enter on every cycle, and its result leaves exactly N cycles later. The raw final partial remainder is delivered without correction, together with a sign flag. A downstream consumer that needs the true remainder adds the divisor back when the flag is set.

The block is intended for datapaths that must sustain a high division rate but need little area per stage.

Top module: `nrdiv_pipe`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, and it stays 0 on the first clock edge after reset is released.
- R2: `out_valid` is 1 in cycle c+N exactly when `in_valid` was 1 in cycle c. Here a cycle is the interval between rising edges, and the input is sampled on the edge that ends cycle c.
- R3: The operands are fractions. `divisor` has weight 2^-N per LSB and its bit N-1 is 1, so D lies in [1/2, 1). `dividend` has weight 2^-2N per LSB, and its upper half `dividend[2N-1:N]` is below `divisor`. Under these conditions, `quotient` (weight 2^-N per LSB) equals floor(dividend / divisor) in integer terms. This includes the corner where the divisor is 2^(N-1) and the dividend is divisor·2^N − 1, which gives an all-ones quotient.
- R4: When `quotient[0]` is 1, `rem_neg` is 0 and `remainder` equals dividend − quotient·divisor, an integer in [0, divisor).
- R5: When `quotient[0]` is 0, `rem_neg` is 1 and {`rem_neg`,`remainder`} is the (N+1)-bit two's complement of dividend − quotient·divisor − divisor. For example, a zero dividend gives −divisor.
- R6: Operand values presented while `in_valid` is 0 produce no result, and `out_valid` stays 0 for them.
- R7: Divisions issued on consecutive cycles each produce a correct result on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operands are present this cycle |
| dividend | input | 2N | Fractional dividend, upper half below divisor |
| divisor | input | N | Normalized fractional divisor, MSB set |
| out_valid | output | 1 | Result is present this cycle |
| quotient | output | N | Fractional quotient |
| remainder | output | N | Low N bits of the raw final partial remainder |
| rem_neg | output | 1 | Sign of the raw final partial remainder |

## Verification
Every result is due N cycles after its operands are taken. The bench keeps a history of what it drove and, on each falling edge, compares the outputs against the entry recorded N cycles earlier. A history entry that was idle, including one where junk operands were held with `in_valid` low, must show `out_valid` at 0. A valid entry must show the integer quotient and a raw remainder whose expected sign is chosen by the parity of that quotient. Sampling on the falling edge keeps each comparison a full half period away from the register updates.

// File: rtl/nrdiv_pipe.sv
module nrdiv_pipe #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           out_valid,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic           rem_neg
);

  localparam int RW = N + 1;
  localparam int SW = N + 2;

  for (genvar k = 0; k < N; k++) begin : row
    logic          v_in;
    logic          sub;
    logic [RW-1:0] pr_in;
    logic [N-1:0]  x_in;
    logic [N-1:0]  dv_in;
    logic [SW-1:0] shifted, addend, sum;
    logic          v_q;
    logic [RW-1:0] pr_q;
    logic [N-1:0]  x_q;

    if (k == 0) begin : g_head
      assign v_in  = in_valid;
      assign sub   = 1'b1;
      assign pr_in = {1'b0, dividend[2*N-1:N]};
      assign x_in  = dividend[N-1:0];
      assign dv_in = divisor;
    end else begin : g_link
      assign v_in  = row[k-1].v_q;
      assign sub   = row[k-1].x_q[0];
      assign pr_in = row[k-1].pr_q;
      assign x_in  = row[k-1].x_q;
      assign dv_in = row[k-1].g_fwd.dv_q;
    end

    assign shifted = {pr_in, x_in[N-1]};
    assign addend  = sub ? ~{2'b00, dv_in} : {2'b00, dv_in};
    assign sum     = shifted + addend + {{(SW-1){1'b0}}, sub};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_in;

    always_ff @(posedge clk) begin
      pr_q <= sum[RW-1:0];
      x_q  <= {x_in[N-2:0], ~sum[SW-1]};
    end

    if (k < N - 1) begin : g_fwd
      logic [N-1:0] dv_q;
      always_ff @(posedge clk) dv_q <= dv_in;
    end
  end

  assign out_valid = row[N-1].v_q;
  assign quotient  = row[N-1].x_q;
  assign remainder = row[N-1].pr_q[N-1:0];
  assign rem_neg   = row[N-1].pr_q[N];

endmodule

// File: rtl/nrdiv_pipe_chk.sv
module nrdiv_pipe_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [2*N-1:0] dividend,
  input logic [N-1:0]   divisor,
  input logic           out_valid,
  input logic [N-1:0]   quotient,
  input logic [N-1:0]   remainder,
  input logic           rem_neg
);

  logic [N-1:0]   vsh;
  logic [2*N-1:0] psh [N];
  logic [N-1:0]   dsh [N];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vsh <= '0;
    else        vsh <= {vsh[N-2:0], in_valid};

  always_ff @(posedge clk) begin
    psh[0] <= dividend;
    dsh[0] <= divisor;
    for (int i = 1; i < N; i++) begin
      psh[i] <= psh[i-1];
      dsh[i] <= dsh[i-1];
    end
  end

  logic [2*N-1:0] qx, dx, prod;
  logic [2*N+1:0] recon;
  assign qx    = {{N{1'b0}}, quotient};
  assign dx    = {{N{1'b0}}, dsh[N-1]};
  assign prod  = qx * dx;
  assign recon = {2'b00, prod} + {{(N+1){rem_neg}}, rem_neg, remainder}
               + (rem_neg ? {{(N+2){1'b0}}, dsh[N-1]} : '0);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[N-1]);

  a_r3_reconstruct: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> recon == {2'b00, psh[N-1]});

  a_r4_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rem_neg) |-> remainder < dsh[N-1]);

  a_r5_neg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rem_neg) |->
      ({1'b1, {N{1'b0}}} - {1'b0, remainder}) <= {1'b0, dsh[N-1]});

endmodule

bind nrdiv_pipe nrdiv_pipe_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
  .divisor(divisor), .out_valid(out_valid), .quotient(quotient),
  .remainder(remainder), .rem_neg(rem_neg)
);

// File: tb/nrdiv_pipe_bench.sv
module nrdiv_pipe_bench;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [2*N-1:0] dividend = '0;
  logic [N-1:0]   divisor = '0;
  logic           out_valid;
  logic [N-1:0]   quotient, remainder;
  logic           rem_neg;

  always #2.5 clk = ~clk;

  nrdiv_pipe #(.N(N)) u_nrdiv_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
    .divisor(divisor), .out_valid(out_valid), .quotient(quotient),
    .remainder(remainder), .rem_neg(rem_neg)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string vtag = "R2";
  bit             hv [4096];
  logic [2*N-1:0] hp [4096];
  logic [N-1:0]   hd [4096];
  logic [15:0]    lfsr = 16'hACE1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2*N-1:0] p, logic [N-1:0] d);
    @(negedge clk);
    if (cyc >= N && hv[cyc-N]) begin
      int q, r, raw;
      logic [N:0] e;
      q   = int'(hp[cyc-N]) / int'(hd[cyc-N]);
      r   = int'(hp[cyc-N]) % int'(hd[cyc-N]);
      raw = (q % 2 == 1) ? r : r - int'(hd[cyc-N]);
      e   = raw[N:0];
      chk(vtag, "out_valid", int'(out_valid), 1);
      chk("R3", "quotient", int'(quotient), q);
      if (q % 2 == 1) chk("R4", "remainder", int'({rem_neg, remainder}), int'(e));
      else            chk("R5", "remainder", int'({rem_neg, remainder}), int'(e));
    end else begin
      chk("R6", "out_valid idle", int'(out_valid), 0);
    end
    in_valid = v; dividend = p; divisor = d;
    hv[cyc] = v; hp[cyc] = p; hd[cyc] = d;
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < N + 1; i++) step(1'b0, '0, '0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "out_valid in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after release", int'(out_valid), 0);
  endtask

  task automatic t_patterns();
    vtag = "R2";
    step(1'b1, 16'h40_00, 8'h80);
    drain();
    step(1'b1, 16'h7F_FF, 8'hFF);
    drain();
    step(1'b1, 16'h55_AA, 8'hC3);
    drain();
  endtask

  task automatic t_min_divisor();
    vtag = "R2";
    step(1'b1, 16'h7F_FF, 8'h80);
    drain();
  endtask

  task automatic t_zero_dividend();
    vtag = "R2";
    step(1'b1, 16'h00_00, 8'hA5);
    drain();
  endtask

  task automatic t_ignored();
    vtag = "R2";
    for (int i = 0; i < 4; i++) step(1'b0, 16'h3C_5A, 8'h9B);
    drain();
  endtask

  task automatic t_stream();
    vtag = "R7";
    for (int i = 0; i < 24; i++) begin
      logic [N-1:0] d, hi, lo;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d  = 8'h80 | lfsr[7:0];
      hi = lfsr[15:8] % d;
      lo = lfsr[11:4];
      step(1'b1, {hi, lo}, d);
    end
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_min_divisor();
    t_zero_dividend();
    t_ignored();
    t_stream();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule